// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block sits between a register bus and a card-side command engine. Software first loads a 32-bit argument. It then writes a command word that carries a 6-bit index, response-type flags, mode flags and an enable bit. With enable set, the block raises a one-cycle request toward the card with the index and the argument, and it waits for the card side to report completion.

The completion strobe carries a byte count and up to sixteen response bytes. The block checks the count against the response type that was requested. It loads four response words, or it records a timeout. It also sets sticky status flags. Software clears the flags through a write-one-to-clear register. Two interrupt lines follow the status word through their own masks.

Register word addresses, with the default parameters:
- 0: argument
- 1: command
- 2 to 5: response words 0 to 3
- 6: status, read only
- 7: clear, write only
- 8: interrupt mask 0
- 9: interrupt mask 1

Top module: `mmc_cmd_ctrl`

## Requirements
- R1: After reset, every readable register reads zero, `card_req` is low and both `irq` bits are low.
- R2: A command write (address 1) with bit 10 set and bits 8 and 9 clear raises `card_req` for exactly one cycle, starting the cycle after the write. `card_idx` carries bits 5:0 of the write and `card_arg` carries the argument register. Command bit 10 reads 1 while the block waits and reads 0 once the card reports done.
- R3: A command write with bit 10 set and either bit 8 or bit 9 set issues no request. Its bit 10 reads 0 from the next cycle, and its other bits are kept.
- R4: When command bit 6 is clear, the completion sets status bit 7 whatever the byte count, and the response words keep their values.
- R5: When bit 6 is set and bit 7 is clear, a byte count of 4 sets status bit 6. Response word 0 becomes card bytes 0 to 3 in big-endian order, and words 1 to 3 become zero. Card byte k sits at `card_data[127-8k -: 8]`.
- R6: When bit 6 is set, a byte count of 16 sets status bit 6 whether or not bit 7 is set. Word j becomes card bytes 4j to 4j+3 in big-endian order, and bit 0 of word 3 is forced to 0.
- R7: When bit 6 is set, a byte count of 0, a count of 4 with bit 7 set, or any count other than 4 or 16 sets status bit 2 and leaves the response words unchanged.
- R8: Status bits stay set until cleared. A write to the clear register (address 7) clears exactly the status bits that are one in data bits 10:0, and higher data bits have no effect.
- R9: `irq[i]` is high exactly when the status word ANDed with mask register i (address 8+i) is nonzero. It follows mask and status changes in the same cycle they become visible.
- R10: A command write while a request is outstanding is ignored. A `card_done` pulse while no request is outstanding changes neither the status nor the response words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read word address |
| reg_rdata | output | 32 | Register read data, combinational |
| card_req | output | 1 | One-cycle command request to the card side |
| card_idx | output | 6 | Command index presented with the request |
| card_arg | output | 32 | Command argument presented with the request |
| card_done | input | 1 | Completion strobe from the card side |
| card_len | input | 5 | Response byte count delivered with the strobe |
| card_data | input | 128 | Response bytes, byte 0 in the top eight bits |
| irq | output | 2 | Masked status interrupt lines |

## Verification
The embedded assertions watch several properties on every cycle:
- the request is a single-cycle pulse, and the enable bit is set while the request is raised;
- the sequencer holds its state and its command word while it waits;
- at most one completion event is raised per strobe;
- status flags stay sticky, and any flag written to the clear register is gone on the next cycle;
- after a 16-byte load, the last response bit is zero, and a timeout leaves the response words untouched.

Only the directed scenarios can show the rest: the big-endian word placement, the zeroing of words 1 to 3 on a short reply, the full list of timeout byte counts, the suppressed issue in the two excluded modes, the interrupt masking, and the rejection of stray writes and strobes.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;
  // Command word layout
  localparam int IDX_W       = 6;
  localparam int CMD_W       = 11;
  localparam int BIT_RESP    = 6;
  localparam int BIT_LONG    = 7;
  localparam int BIT_WAITIRQ = 8;
  localparam int BIT_PEND    = 9;
  localparam int BIT_EN      = 10;
  // Status word layout
  localparam int STAT_W      = 11;
  localparam int ST_TIMEOUT  = 2;
  localparam int ST_RESPEND  = 6;
  localparam int ST_SENT     = 7;

  typedef enum logic {SEQ_IDLE, SEQ_WAIT} seq_state_e;
endpackage

// File: rtl/mmc_cmd_seq.sv
module mmc_cmd_seq
  import mmc_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             card_done,
  output logic             issue,
  output logic             done_take,
  output logic [CMD_W-1:0] cmd_word
);
  seq_state_e       state_q, state_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic             issue_q, issue_d;

  always_comb begin
    state_d   = state_q;
    cmd_d     = cmd_q;
    issue_d   = 1'b0;
    done_take = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (cmd_wr) begin
          cmd_d = cmd_wdata;
          if (cmd_wdata[BIT_EN]) begin
            if (cmd_wdata[BIT_WAITIRQ] || cmd_wdata[BIT_PEND]) begin
              cmd_d[BIT_EN] = 1'b0;
            end else begin
              issue_d = 1'b1;
              state_d = SEQ_WAIT;
            end
          end
        end
      end
      SEQ_WAIT: begin
        if (card_done) begin
          done_take     = 1'b1;
          cmd_d[BIT_EN] = 1'b0;
          state_d       = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cmd_q   <= '0;
      issue_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      issue_q <= issue_d;
    end
  end

  assign issue    = issue_q;
  assign cmd_word = cmd_q;

  // R2
  issue_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_q |=> !issue_q);
  // R2
  issue_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_q |-> cmd_q[BIT_EN]);
  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WAIT && !card_done) |=> (state_q == SEQ_WAIT && $stable(cmd_q)));
endmodule

// File: rtl/mmc_resp_eval.sv
module mmc_resp_eval #(
  parameter int DATA_W     = 32,
  parameter int RESP_WORDS = 4,
  parameter int LEN_W      = $clog2(RESP_WORDS * DATA_W / 8 + 1)
) (
  input  logic                                 take,
  input  logic                                 want_resp,
  input  logic                                 want_long,
  input  logic [LEN_W-1:0]                     card_len,
  input  logic [RESP_WORDS*DATA_W-1:0]         card_data,
  output logic                                 set_sent,
  output logic                                 set_resp,
  output logic                                 set_timeout,
  output logic [RESP_WORDS-1:0][DATA_W-1:0]    words
);
  localparam int SHORT_BYTES = DATA_W / 8;
  localparam int LONG_BYTES  = RESP_WORDS * SHORT_BYTES;
  localparam int TOT_W       = RESP_WORDS * DATA_W;

  logic len_short, len_long, len_ok;

  assign len_short   = (card_len == LEN_W'(SHORT_BYTES));
  assign len_long    = (card_len == LEN_W'(LONG_BYTES));
  assign len_ok      = (len_short && !want_long) || len_long;
  assign set_sent    = take && !want_resp;
  assign set_resp    = take && want_resp && len_ok;
  assign set_timeout = take && want_resp && !len_ok;

  for (genvar j = 0; j < RESP_WORDS; j++) begin : g_word
    logic [DATA_W-1:0] slice;
    assign slice = card_data[TOT_W-1-j*DATA_W -: DATA_W];
    if (j == 0) begin : g_first
      assign words[j] = slice;
    end else if (j == RESP_WORDS - 1) begin : g_last
      assign words[j] = len_long ? {slice[DATA_W-1:1], 1'b0} : '0;
    end else begin : g_mid
      assign words[j] = len_long ? slice : '0;
    end
  end
endmodule

// File: rtl/mmc_stat_irq.sv
module mmc_stat_irq
  import mmc_cmd_pkg::*;
#(
  parameter int NUM_IRQ = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [STAT_W-1:0]              set_vec,
  input  logic                           clr_en,
  input  logic [STAT_W-1:0]              clr_bits,
  input  logic [NUM_IRQ-1:0]             mask_we,
  input  logic [STAT_W-1:0]              mask_wdata,
  output logic [STAT_W-1:0]              status,
  output logic [NUM_IRQ-1:0][STAT_W-1:0] masks,
  output logic [NUM_IRQ-1:0]             irq
);
  logic [STAT_W-1:0] status_q, status_d;

  always_comb begin
    status_d = status_q;
    if (clr_en) status_d = status_d & ~clr_bits;
    status_d = status_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status = status_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic [STAT_W-1:0] mask_q, mask_d;
    always_comb begin
      mask_d = mask_q;
      if (mask_we[i]) mask_d = mask_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
    end
    assign masks[i] = mask_q;
    assign irq[i]   = |(status_q & mask_q);
  end

  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((status_q & $past(clr_bits & ~set_vec)) == '0));
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R7
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
endmodule

// File: rtl/mmc_cmd_ctrl.sv
module mmc_cmd_ctrl
  import mmc_cmd_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int RESP_WORDS = 4,
  parameter int NUM_IRQ    = 2,
  parameter int LEN_W      = $clog2(RESP_WORDS * DATA_W / 8 + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [ADDR_W-1:0]            reg_waddr,
  input  logic [DATA_W-1:0]            reg_wdata,
  input  logic [ADDR_W-1:0]            reg_raddr,
  output logic [DATA_W-1:0]            reg_rdata,
  output logic                         card_req,
  output logic [IDX_W-1:0]             card_idx,
  output logic [DATA_W-1:0]            card_arg,
  input  logic                         card_done,
  input  logic [LEN_W-1:0]             card_len,
  input  logic [RESP_WORDS*DATA_W-1:0] card_data,
  output logic [NUM_IRQ-1:0]           irq
);
  localparam int A_ARG    = 0;
  localparam int A_CMD    = 1;
  localparam int A_RESP0  = 2;
  localparam int A_STATUS = A_RESP0 + RESP_WORDS;
  localparam int A_CLEAR  = A_STATUS + 1;
  localparam int A_MASK0  = A_CLEAR + 1;
  localparam int LONG_BYTES = RESP_WORDS * DATA_W / 8;

  logic [DATA_W-1:0]                arg_q, arg_d;
  logic [RESP_WORDS-1:0][DATA_W-1:0] resp_q, resp_d, words;
  logic [CMD_W-1:0]                 cmd_word;
  logic                             done_take, set_sent, set_resp, set_timeout;
  logic [STAT_W-1:0]                set_vec, status;
  logic [NUM_IRQ-1:0][STAT_W-1:0]   masks;
  logic [NUM_IRQ-1:0]               mask_we;
  logic                             cmd_wr, clr_en;

  assign cmd_wr = reg_wr && (reg_waddr == ADDR_W'(A_CMD));
  assign clr_en = reg_wr && (reg_waddr == ADDR_W'(A_CLEAR));

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mwe
    assign mask_we[i] = reg_wr && (reg_waddr == ADDR_W'(A_MASK0 + i));
  end

  mmc_cmd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (reg_wdata[CMD_W-1:0]),
    .card_done (card_done),
    .issue     (card_req),
    .done_take (done_take),
    .cmd_word  (cmd_word)
  );

  mmc_resp_eval #(
    .DATA_W     (DATA_W),
    .RESP_WORDS (RESP_WORDS),
    .LEN_W      (LEN_W)
  ) u_eval (
    .take        (done_take),
    .want_resp   (cmd_word[BIT_RESP]),
    .want_long   (cmd_word[BIT_LONG]),
    .card_len    (card_len),
    .card_data   (card_data),
    .set_sent    (set_sent),
    .set_resp    (set_resp),
    .set_timeout (set_timeout),
    .words       (words)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[ST_SENT]    = set_sent;
    set_vec[ST_RESPEND] = set_resp;
    set_vec[ST_TIMEOUT] = set_timeout;
  end

  mmc_stat_irq #(.NUM_IRQ(NUM_IRQ)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_en     (clr_en),
    .clr_bits   (reg_wdata[STAT_W-1:0]),
    .mask_we    (mask_we),
    .mask_wdata (reg_wdata[STAT_W-1:0]),
    .status     (status),
    .masks      (masks),
    .irq        (irq)
  );

  always_comb begin
    arg_d  = arg_q;
    resp_d = resp_q;
    if (reg_wr && (reg_waddr == ADDR_W'(A_ARG))) arg_d = reg_wdata;
    if (set_resp) resp_d = words;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q  <= '0;
      resp_q <= '0;
    end else begin
      arg_q  <= arg_d;
      resp_q <= resp_d;
    end
  end

  assign card_idx = cmd_word[IDX_W-1:0];
  assign card_arg = arg_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == ADDR_W'(A_ARG))    reg_rdata = arg_q;
    if (reg_raddr == ADDR_W'(A_CMD))    reg_rdata = DATA_W'(cmd_word);
    if (reg_raddr == ADDR_W'(A_STATUS)) reg_rdata = DATA_W'(status);
    for (int j = 0; j < RESP_WORDS; j++) begin
      if (reg_raddr == ADDR_W'(A_RESP0 + j)) reg_rdata = resp_q[j];
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (reg_raddr == ADDR_W'(A_MASK0 + i)) reg_rdata = DATA_W'(masks[i]);
    end
  end

  // R6
  long_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_resp && card_len == LEN_W'(LONG_BYTES)) |=> !resp_q[RESP_WORDS-1][0]);
  // R7
  timeout_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_timeout || set_sent) |=> $stable(resp_q));
endmodule

// File: tb/tb_mmc_cmd_ctrl.sv
module tb_mmc_cmd_ctrl;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr;
  logic [3:0]   reg_waddr, reg_raddr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         card_req, card_done;
  logic [5:0]   card_idx;
  logic [31:0]  card_arg;
  logic [4:0]   card_len;
  logic [127:0] card_data;
  logic [1:0]   irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmc_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .card_req(card_req), .card_idx(card_idx), .card_arg(card_arg),
    .card_done(card_done), .card_len(card_len), .card_data(card_data),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic reply(input logic [4:0] len, input logic [127:0] data);
    @(negedge clk);
    card_done = 1'b1; card_len = len; card_data = data;
    @(negedge clk);
    card_done = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic chk_resp(input string req, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    chk_reg(req, 4'd2, w0);
    chk_reg(req, 4'd3, w1);
    chk_reg(req, 4'd4, w2);
    chk_reg(req, 4'd5, w3);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 10; a++) chk_reg("R1 reg", 4'(a), 32'h0);
    chk("R1 card_req", {31'b0, card_req}, 32'h0);
    chk("R1 irq", {30'b0, irq}, 32'h0);
  endtask

  task automatic t_no_resp;
    wr(4'd0, 32'h1234_5678);
    wr(4'd1, 32'h0000_0415);
    chk("R2 req high", {31'b0, card_req}, 32'h1);
    chk("R2 idx", {26'b0, card_idx}, 32'h15);
    chk("R2 arg", card_arg, 32'h1234_5678);
    chk_reg("R2 enable while waiting", 4'd1, 32'h415);
    @(negedge clk);
    chk("R2 req one cycle", {31'b0, card_req}, 32'h0);
    reply(5'd0, '0);
    chk_reg("R4 sent flag", 4'd6, 32'h80);
    chk_reg("R2 enable cleared", 4'd1, 32'h015);
    chk_resp("R4 resp kept", 0, 0, 0, 0);
  endtask

  task automatic t_short;
    wr(4'd7, 32'h7FF);
    wr(4'd1, 32'h0000_0451);
    reply(5'd4, 128'hDEADBEEF_11111111_22222222_33333333);
    chk_reg("R5 resp end", 4'd6, 32'h40);
    chk_resp("R5 short words", 32'hDEADBEEF, 0, 0, 0);
  endtask

  task automatic t_long;
    wr(4'd7, 32'h7FF);
    wr(4'd1, 32'h0000_04C2);
    reply(5'd16, 128'h00112233_44556677_8899AABB_CCDDEEFF);
    chk_reg("R6 resp end", 4'd6, 32'h40);
    chk_resp("R6 long words", 32'h00112233, 32'h44556677, 32'h8899AABB, 32'hCCDDEEFE);
    wr(4'd7, 32'h7FF);
    wr(4'd1, 32'h0000_0449);
    reply(5'd16, 128'hFEDCBA98_76543211_0F1E2D3C_4B5A6979);
    chk_reg("R6 16 bytes on short request", 4'd6, 32'h40);
    chk_resp("R6 words on short request", 32'hFEDCBA98, 32'h76543211, 32'h0F1E2D3C, 32'h4B5A6978);
  endtask

  task automatic t_timeout;
    wr(4'd7, 32'h7FF);
    wr(4'd1, 32'h0000_0443);
    reply(5'd0, 128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA);
    chk_reg("R7 zero bytes", 4'd6, 32'h04);
    wr(4'd7, 32'h7FF);
    wr(4'd1, 32'h0000_04C3);
    reply(5'd4, 128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA);
    chk_reg("R7 short on long", 4'd6, 32'h04);
    wr(4'd7, 32'h7FF);
    wr(4'd1, 32'h0000_0443);
    reply(5'd8, 128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA);
    chk_reg("R7 odd count", 4'd6, 32'h04);
    chk_resp("R7 resp kept", 32'hFEDCBA98, 32'h76543211, 32'h0F1E2D3C, 32'h4B5A6978);
  endtask

  task automatic t_modes;
    wr(4'd7, 32'h7FF);
    wr(4'd1, 32'h0000_0507);
    chk("R3 no req irq mode", {31'b0, card_req}, 32'h0);
    chk_reg("R3 irq mode cmd", 4'd1, 32'h107);
    wr(4'd1, 32'h0000_0608);
    chk("R3 no req pend mode", {31'b0, card_req}, 32'h0);
    chk_reg("R3 pend mode cmd", 4'd1, 32'h208);
    chk_reg("R3 status untouched", 4'd6, 32'h0);
  endtask

  task automatic t_busy;
    wr(4'd1, 32'h0000_0445);
    @(negedge clk);
    wr(4'd1, 32'h0000_0409);
    chk("R10 no second req", {31'b0, card_req}, 32'h0);
    chk_reg("R10 cmd kept", 4'd1, 32'h445);
    reply(5'd4, 128'hCAFEF00D_0000_0000_0000_0000_0000_0000);
    chk_reg("R10 first completes", 4'd6, 32'h40);
    chk_reg("R5 busy resp0", 4'd2, 32'hCAFEF00D);
    reply(5'd16, {128{1'b1}});
    chk_reg("R10 idle done status", 4'd6, 32'h40);
    chk_resp("R10 idle done resp", 32'hCAFEF00D, 0, 0, 0);
  endtask

  task automatic t_clear;
    wr(4'd7, 32'h7FF);
    wr(4'd1, 32'h0000_0400);
    reply(5'd0, '0);
    wr(4'd1, 32'h0000_0440);
    reply(5'd0, '0);
    chk_reg("R8 both flags", 4'd6, 32'h84);
    wr(4'd7, 32'hFFFF_F800);
    chk_reg("R8 high bits ignored", 4'd6, 32'h84);
    wr(4'd7, 32'h0000_0004);
    chk_reg("R8 partial clear", 4'd6, 32'h80);
  endtask

  task automatic t_irq;
    chk("R9 no mask", {30'b0, irq}, 32'h0);
    wr(4'd8, 32'h80);
    chk("R9 mask0 hit", {30'b0, irq}, 32'h1);
    wr(4'd9, 32'h04);
    chk("R9 mask1 miss", {30'b0, irq}, 32'h1);
    wr(4'd9, 32'h84);
    chk("R9 both", {30'b0, irq}, 32'h3);
    chk_reg("R9 mask1 readback", 4'd9, 32'h84);
    wr(4'd7, 32'h80);
    chk("R9 after clear", {30'b0, irq}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
    card_done = 1'b0; card_len = '0; card_data = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_no_resp;
    t_short;
    t_long;
    t_timeout;
    t_modes;
    t_busy;
    t_clear;
    t_irq;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule